// File: doc/BRIEF.md
# DDR Bandwidth Load Monitor

This block measures how busy each of two DRAM channels is over a software-defined window. Every channel owns a pair of counters: one counts monitor-clock cycles while the window is open, the other counts cycles in which that channel's access strobe is high. Each access unit represents four data transfers, so the consumer scales the access count by four before it divides by the cycle count to get a load ratio.

Software drives the block through a small single-cycle register port. A control register holds the memory-type flags and the enables. It uses a half-word write mask, so a single store can change selected bits and leave the rest alone. To open a window, software sets the software-enable bit. The rising edge of that bit clears all counters. To close the window, software writes the enable back to zero. The counters then hold their values and can be read one after another, and both channels stay a coherent snapshot of the same window.

Top module: `ddr_load_monitor`

## Requirements
- R1: After reset the control register reads 0, all four counters read 0 and `bus_rdata` is 0.
- R2: A write to offset 0x04 changes control bit n (n = 0..4) only when written bit n+16 is 1; the new value is written bit n. Bits whose mask is 0 keep their value. Bit 0 is time-count enable, bit 1 is software enable, bit 2 selects LPDDR3, bit 3 is hardware-mode enable, bit 4 selects LPDDR4.
- R3: Writing 0x001F0000 to offset 0x04 clears control bits 4:0 in one access.
- R4: A 0-to-1 change of control bit 1 clears all four counters in the cycle after the write. Counting starts in the cycle after that, so no value from an earlier window survives.
- R5: While bit 1 is set, and outside the clearing cycle, each channel's cycle counter increases by 1 on every clock.
- R6: While counting, a channel's access counter increases by 1 on each clock in which its `acc_strobe` bit is high (bit 0 is channel 0). The two channels count independently.
- R7: After bit 1 is written to 0 with its mask bit set, no counter changes, whatever the strobes do.
- R8: Read offsets are fixed. Control is at 0x04, in bits 4:0 with the upper bits 0. Channel 0 has its cycle count at 0x28 and its access count at 0x2C. Channel 1 has its cycle count at 0x3C and its access count at 0x40.
- R9: A counter that reaches all-ones stays at all-ones instead of wrapping.
- R10: Reads of any other offset return 0. Writes to any offset other than 0x04 change nothing.
- R11: `bus_rdata` shows the register selected by `bus_addr` one clock edge after the address is presented. It does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_strobe | input | NUM_CH | Per-channel accepted-access strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write enable, sampled on the clock edge |
| bus_wdata | input | 32 | Write data (mask in 31:16, value in 15:0) |
| bus_rdata | output | 32 | Registered read data |

## Verification
A corrupted control bit shows up the first time software reads offset 0x04, and it also shows up in the counters. A stuck enable makes the cycle count differ from the window length on the very next readout. A missed clear on the enable edge leaves values from the previous window, which inflates both counts of the second window. Counters that keep running after the stop command show up as a difference between two readouts taken a few cycles apart. Saturation faults are checked on a narrow-counter copy, where a wrap returns a small value instead of all-ones within one window.

// File: rtl/ldmon_pkg.sv
package ldmon_pkg;
  localparam int DATA_W    = 32;
  localparam int CTRL_BITS = 5;
  localparam int MASK_OFS  = 16;

  localparam int CB_TIME = 0;
  localparam int CB_SW   = 1;
  localparam int CB_LP3  = 2;
  localparam int CB_HW   = 3;
  localparam int CB_LP4  = 4;

  localparam int OFS_CTRL    = 'h04;
  localparam int OFS_CH_BASE = 'h28;
  localparam int CH_STRIDE   = 20;
  localparam int OFS_ACC_REL = 4;

  function automatic int chan_tot_ofs(input int ch);
    return OFS_CH_BASE + ch * CH_STRIDE;
  endfunction

  function automatic int chan_acc_ofs(input int ch);
    return chan_tot_ofs(ch) + OFS_ACC_REL;
  endfunction

  function automatic logic [CTRL_BITS-1:0] masked_merge(
    input logic [CTRL_BITS-1:0] old_val,
    input logic [CTRL_BITS-1:0] new_val,
    input logic [CTRL_BITS-1:0] sel
  );
    return (old_val & ~sel) | (new_val & sel);
  endfunction
endpackage

// File: rtl/ldmon_ctrl_reg.sv
module ldmon_ctrl_reg
  import ldmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [CTRL_BITS-1:0] ctrl_q,
  output logic                 cnt_run,
  output logic                 cnt_clear
);
  logic sw_prev;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:MASK_OFS+CTRL_BITS],
                          wdata[MASK_OFS-1:CTRL_BITS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= masked_merge(ctrl_q, wdata[CTRL_BITS-1:0],
                             wdata[MASK_OFS +: CTRL_BITS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_prev <= 1'b0;
    else        sw_prev <= ctrl_q[CB_SW];
  end

  assign cnt_clear = ctrl_q[CB_SW] & ~sw_prev;
  assign cnt_run   = ctrl_q[CB_SW] & ~cnt_clear;
endmodule

// File: rtl/ldmon_chan_counter.sv
module ldmon_chan_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             strobe,
  output logic [CNT_W-1:0] tot,
  output logic [CNT_W-1:0] acc
);
  function automatic logic [CNT_W-1:0] sat_inc(
    input logic [CNT_W-1:0] v,
    input logic             en
  );
    return (en && (v != '1)) ? v + CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot <= '0;
      acc <= '0;
    end else if (clr) begin
      tot <= '0;
      acc <= '0;
    end else begin
      tot <= sat_inc(tot, run);
      acc <= sat_inc(acc, run & strobe);
    end
  end
endmodule

// File: rtl/ldmon_readback.sv
module ldmon_readback
  import ldmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CTRL_BITS-1:0]          ctrl_q,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  tot,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  acc,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFS_CTRL)) rd_next = DATA_W'(ctrl_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(chan_tot_ofs(c))) rd_next = DATA_W'(tot[c]);
      if (addr == ADDR_W'(chan_acc_ofs(c))) rd_next = DATA_W'(acc[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end
endmodule

// File: rtl/ddr_load_monitor.sv
module ddr_load_monitor
  import ldmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] acc_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic                         ctrl_we;
  logic [CTRL_BITS-1:0]         ctrl_q;
  logic                         cnt_run;
  logic                         cnt_clear;
  logic [NUM_CH-1:0][CNT_W-1:0] tot_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] acc_cnt;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

  ldmon_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .cnt_run   (cnt_run),
    .cnt_clear (cnt_clear)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ldmon_chan_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cnt_run),
      .clr    (cnt_clear),
      .strobe (acc_strobe[ch]),
      .tot    (tot_cnt[ch]),
      .acc    (acc_cnt[ch])
    );
  end

  ldmon_readback #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .ctrl_q (ctrl_q),
    .tot    (tot_cnt),
    .acc    (acc_cnt),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/ldmon_chk.sv
module ldmon_chk
  import ldmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [31:0]                  bus_rdata,
  input logic [CTRL_BITS-1:0]         ctrl_q,
  input logic                         cnt_run,
  input logic                         cnt_clear,
  input logic [NUM_CH-1:0][CNT_W-1:0] tot_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] acc_cnt
);
  // R2: control only moves on a write to its own offset
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |=> (bus_rdata == '0));

  assert_ctrl_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_CTRL)) |=> (bus_rdata[31:CTRL_BITS] == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear |=> (tot_cnt[ch] == '0 && acc_cnt[ch] == '0));

    assert_tot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_run && tot_cnt[ch] != '1) |=> (tot_cnt[ch] == $past(tot_cnt[ch]) + CNT_W'(1)));

    assert_acc_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cnt[ch] <= tot_cnt[ch]);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_run && !cnt_clear) |=> ($stable(tot_cnt[ch]) && $stable(acc_cnt[ch])));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_cnt[ch] == '1 && !cnt_clear) |=> (tot_cnt[ch] == '1));
  end
endmodule

bind ddr_load_monitor ldmon_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ctrl_q    (ctrl_q),
  .cnt_run   (cnt_run),
  .cnt_clear (cnt_clear),
  .tot_cnt   (tot_cnt),
  .acc_cnt   (acc_cnt)
);

// File: tb/ddr_load_monitor_test.sv
module ddr_load_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_TOT0 = 8'h28;
  localparam logic [7:0] A_ACC0 = 8'h2C;
  localparam logic [7:0] A_TOT1 = 8'h3C;
  localparam logic [7:0] A_ACC1 = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_strobe = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] rdata_n;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_load_monitor uut (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  ddr_load_monitor #(.CNT_W(6)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vn);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata; vn = rdata_n;
  endtask

  function automatic bit pat(input int p, input int ch, input int j);
    case (p)
      0: return (ch == 0);
      1: return (ch == 0) ? j[0] : !j[0];
      2: return (ch == 0) ? (j % 3 == 0) : 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  // opens a window of n counted cycles with pattern p, closes it, checks counters
  task automatic t_window(input int p, input int n, output int e0, output int e1);
    logic [31:0] v, vn;
    e0 = 0; e1 = 0;
    wr(A_CTRL, 32'h001F_0000);
    wr(A_CTRL, 32'h0004_0004);
    wr(A_CTRL, 32'h0002_0002);
    acc_strobe = '0;
    @(posedge clk);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      acc_strobe = {pat(p, 1, j), pat(p, 0, j)};
      e0 += int'(pat(p, 0, j));
      e1 += int'(pat(p, 1, j));
      if (j == n - 1) begin
        bus_addr = A_CTRL; bus_wdata = 32'h0002_0000; bus_wr = 1'b1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    bus_wr = 1'b0; acc_strobe = '0;
    rd(A_TOT0, v, vn); chk("R5 tot0 (R4 fresh window)", v, 32'(n));
    rd(A_ACC0, v, vn); chk("R6 acc0", v, 32'(e0));
    rd(A_TOT1, v, vn); chk("R5 tot1", v, 32'(n));
    rd(A_ACC1, v, vn); chk("R6 acc1", v, 32'(e1));
    rd(A_CTRL, v, vn); chk("R8 ctrl after stop", v, 32'h0000_0004);
  endtask

  task automatic t_reset();
    logic [31:0] v, vn;
    chk("R1 rdata at reset", bus_rdata, 32'h0);
    rd(A_CTRL, v, vn); chk("R1 ctrl", v, 32'h0);
    rd(A_TOT0, v, vn); chk("R1 tot0", v, 32'h0);
    rd(A_ACC0, v, vn); chk("R1 acc0", v, 32'h0);
    rd(A_TOT1, v, vn); chk("R1 tot1", v, 32'h0);
    rd(A_ACC1, v, vn); chk("R1 acc1", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v, vn;
    wr(A_CTRL, 32'h0000_001F);
    rd(A_CTRL, v, vn); chk("R2 no mask no change", v, 32'h00);
    wr(A_CTRL, 32'h0005_001F);
    rd(A_CTRL, v, vn); chk("R2 masked set bits 0,2", v, 32'h05);
    wr(A_CTRL, 32'h0004_0000);
    rd(A_CTRL, v, vn); chk("R2 masked clear bit 2", v, 32'h01);
    wr(A_CTRL, 32'h0018_FFF8);
    rd(A_CTRL, v, vn); chk("R2 set bits 3,4 keep 0", v, 32'h19);
    wr(A_CTRL, 32'h001F_0000);
    rd(A_CTRL, v, vn); chk("R3 clear all", v, 32'h00);
  endtask

  task automatic t_windows();
    int e0, e1;
    t_window(0, 17, e0, e1);
    t_window(1, 24, e0, e1);
    t_window(2, 9, e0, e1);
  endtask

  task automatic t_freeze();
    logic [31:0] v, vn;
    int e0, e1;
    t_window(1, 12, e0, e1);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      acc_strobe = 2'b11;
    end
    @(negedge clk);
    acc_strobe = '0;
    rd(A_TOT0, v, vn); chk("R7 tot0 frozen", v, 32'd12);
    rd(A_ACC0, v, vn); chk("R7 acc0 frozen", v, 32'(e0));
    rd(A_TOT1, v, vn); chk("R7 tot1 frozen", v, 32'd12);
    rd(A_ACC1, v, vn); chk("R7 acc1 frozen", v, 32'(e1));
  endtask

  task automatic t_unmapped();
    logic [31:0] v, vn;
    wr(A_TOT0, 32'hFFFF_FFFF);
    wr(8'h00, 32'h001F_001F);
    wr(8'h08, 32'h0002_0002);
    rd(A_CTRL, v, vn); chk("R10 ctrl untouched", v, 32'h04);
    rd(A_TOT0, v, vn); chk("R10 tot0 untouched", v, 32'd12);
    rd(8'h00, v, vn);  chk("R10 read 0x00", v, 32'h0);
    rd(8'h30, v, vn);  chk("R10 read 0x30", v, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v, vn;
    rd(A_CTRL, v, vn);
    bus_addr = A_TOT0;
    #1;
    chk("R11 no change before edge", bus_rdata, 32'h04);
    @(posedge clk);
    @(negedge clk);
    chk("R11 new value after edge", bus_rdata, 32'd12);
  endtask

  task automatic t_sat();
    logic [31:0] v, vn;
    int e0, e1;
    t_window(3, 80, e0, e1);
    rd(A_TOT0, v, vn); chk("R9 narrow tot0 saturates", vn, 32'd63);
    rd(A_ACC1, v, vn); chk("R9 narrow acc1 saturates", vn, 32'd63);
    rd(A_ACC0, v, vn); chk("R9 wide acc0 no saturation", v, 32'd80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_windows();
    t_freeze();
    t_unmapped();
    t_latency();
    t_sat();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule